// File: doc/BRIEF.md
# Configurable 8/16-bit Timer Counter

This block is a timer/counter whose width and counting rule are selected at run time by a three-bit mode field. It can count freely over 8 or 16 bits, clear itself when it hits an 8-bit compare value, or count over 8 or 16 bits for use by capture logic. Capture logic sits outside this block; in those modes only the width decode and the counting apply. The counter advances on a timer-clock enable pulse. The pulse is honoured only while a clock-select field is nonzero, and a prescaler outside the block supplies it.

Software reaches the block through a small byte-wide register port with four addresses: the low count byte, the high count byte (through a temporary byte), the compare value, and a flag register. Two sticky flags, overflow and compare match, are brought out as pins for an interrupt controller. The controller can clear each flag with an acknowledge pulse. Software can clear a flag by writing a one to it.

Top module: `cfg_timer816`

## Requirements
- R1: The count advances by one on a clock edge only when `clk_sel` is nonzero and `tick` is high; otherwise the count holds, and it can still be read and written through the register port.
- R2: A write to the low count byte (address 0) on an edge overrides any increment or compare clear on that edge, and no overflow or compare flag is set by that edge.
- R3: Mode field `mode` = {capture-enable, width, waveform}. 000 is free 8-bit, 001 is 8-bit clear-on-compare, 01x is 16-bit, 10x is 8-bit capture counting, and 11x is 16-bit capture counting. Width is 16 bits exactly when bit 1 is set.
- R4: In 8-bit modes the count runs from 0xFF to 0x00. The overflow flag becomes set on the same edge that the count becomes 0x00.
- R5: In 16-bit modes the count runs from 0xFFFF to 0x0000, setting the overflow flag on that edge. A carry out of the low byte alone does not set it.
- R6: In clear-on-compare mode, an enabled edge that sees the low count equal to the compare value (address 2) loads zero and sets the compare flag. No other mode sets the compare flag.
- R7: Compare writes take effect at once with no buffering. If the compare value is below the count, the counter passes through 0xFF to 0x00, setting overflow, before any match.
- R8: Flags are read at address 3 (bit 0 overflow, bit 1 compare). Writing a 1 to a bit, or pulsing `ovf_ack` / `cmp_ack`, clears that flag. Writing 0 leaves it unchanged. A hardware set on the same edge as a clear leaves the flag set.
- R9: Reading address 0 copies the high count byte into a temporary byte, which address 1 returns. Writing address 1 loads the temporary byte. Writing address 0 then loads the full count with the temporary byte as its high half (16-bit modes).
- R10: Changing `mode` does not alter the low count byte. While an 8-bit mode is selected the high count byte is zero from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Clock-select field; zero stops the counter |
| tick | input | 1 | Timer-clock enable pulse |
| mode | input | 3 | {capture-enable, width, waveform} mode field |
| addr | input | 2 | Register address: 0 count low, 1 count high, 2 compare, 3 flags |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (side effect on address 0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
Two kinds of collision can fall on the same edge. A software write can meet a hardware event: a count write while the counter would increment, wrap, or clear on compare. A flag clear can land on the edge where hardware sets that same flag. The bench sets these up by raising the write strobe on the very negative edge where counting is enabled, with the count parked at 0xFF or at the compare value. It then judges the outcome from the count and flag values read back after that single edge. Separate sweeps over every mode code, several start values and run lengths supply the expected values arithmetically.

// File: rtl/cfg_timer816.sv
module cfg_timer816 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       tick,
  input  logic [2:0] mode,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ovf_ack,
  input  logic       cmp_ack,
  output logic       ovf_flag,
  output logic       cmp_flag
);

  logic [7:0] cnt_lo, cnt_hi, tmp, ocr;
  logic [7:0] lo_n, hi_n;

  wire wide   = mode[1];
  wire ctc    = (mode == 3'b001);
  wire run    = (clk_sel != 3'd0) && tick;
  wire wr_lo  = wr && (addr == 2'd0);
  wire wr_hi  = wr && (addr == 2'd1);
  wire wr_ocr = wr && (addr == 2'd2);
  wire wr_flg = wr && (addr == 2'd3);
  wire lo_max = (cnt_lo == 8'hFF);
  wire wrap   = run && !wr_lo && lo_max && (!wide || cnt_hi == 8'hFF);
  wire match  = run && !wr_lo && ctc && (cnt_lo == ocr);

  always_comb begin
    lo_n = cnt_lo;
    hi_n = wide ? cnt_hi : 8'h00;
    if (wr_lo) begin
      lo_n = wdata;
      hi_n = wide ? tmp : 8'h00;
    end else if (match) begin
      lo_n = 8'h00;
      hi_n = 8'h00;
    end else if (run) begin
      lo_n = cnt_lo + 8'd1;
      hi_n = wide ? cnt_hi + {7'd0, lo_max} : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo   <= 8'h00;
      cnt_hi   <= 8'h00;
      tmp      <= 8'h00;
      ocr      <= 8'h00;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
      if (wr_hi)
        tmp <= wdata;
      else if (rd && addr == 2'd0)
        tmp <= cnt_hi;
      if (wr_ocr)
        ocr <= wdata;
      ovf_flag <= wrap  | (ovf_flag & ~(wr_flg & wdata[0]) & ~ovf_ack);
      cmp_flag <= match | (cmp_flag & ~(wr_flg & wdata[1]) & ~cmp_ack);
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cnt_lo;
      2'd1:    rdata = tmp;
      2'd2:    rdata = ocr;
      default: rdata = {6'd0, cmp_flag, ovf_flag};
    endcase
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !wr) |=> $stable(cnt_lo)); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wdata))); // R2
  AST_WRITE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !ovf_flag && !cmp_flag) |=> (!ovf_flag && !cmp_flag)); // R2
  AST_OVF_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_lo && !wide && lo_max) |=> (ovf_flag && cnt_lo == 8'h00)); // R4
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_lo && ctc && cnt_lo == ocr) |=> (cmp_flag && cnt_lo == 8'h00)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_ack && !(wr_flg && wdata[0])) |=> ovf_flag); // R8
  AST_TMP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd0 && !wr) |=> (tmp == $past(cnt_hi))); // R9
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> (cnt_hi == 8'h00)); // R10

endmodule

// File: tb/cfg_timer816_test.sv
`timescale 1ns/1ps
module cfg_timer816_test;
  logic       clk = 0, rst_n = 0;
  logic [2:0] clk_sel = 0, mode = 0;
  logic       tick = 1, wr = 0, rd = 0, ovf_ack = 0, cmp_ack = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       ovf_flag, cmp_flag;
  int errors = 0, checks = 0;
  bit done = 0;

  cfg_timer816 uut (.clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick),
    .mode(mode), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata),
    .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic cpu_rd(logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic run(int n);
    clk_sel = 3'd1;
    repeat (n) @(negedge clk);
    clk_sel = 3'd0;
  endtask

  task automatic wr16(logic [15:0] v);
    cpu_wr(2'd1, v[15:8]); cpu_wr(2'd0, v[7:0]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] l, h;
    cpu_rd(2'd0, l); cpu_rd(2'd1, h); v = {h, l};
  endtask

  task automatic clr_flags();
    cpu_wr(2'd3, 8'h03);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v;
    int starts[4] = '{0, 200, 250, 255};
    int lens[3] = '{1, 5, 60};
    int ocrs[3] = '{3, 10, 255};
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rd16(v); chk("R1 reset count", v, 0);
    cpu_rd(2'd3, d); chk("R8 reset flags", d, 0);

    // R1: stopped / no tick
    mode = 3'b000; cpu_wr(2'd0, 8'h21);
    repeat (10) @(negedge clk);
    cpu_rd(2'd0, d); chk("R1 clk_sel=0 holds", d, 8'h21);
    tick = 0; run(10); tick = 1;
    cpu_rd(2'd0, d); chk("R1 tick low holds", d, 8'h21);
    clk_sel = 3'd5; @(negedge clk); clk_sel = 0;
    cpu_rd(2'd0, d); chk("R1 any nonzero select runs", d, 8'h22);

    // R4: free 8-bit sweep
    foreach (starts[i]) foreach (lens[j]) begin
      cpu_wr(2'd0, starts[i][7:0]); clr_flags();
      run(lens[j]);
      cpu_rd(2'd0, d); chk("R4 count", d, (starts[i] + lens[j]) % 256);
      cpu_rd(2'd3, d); chk("R4 overflow", d[0], (starts[i] + lens[j]) >= 256);
    end

    // R3: mode decode sweep
    for (int m = 0; m < 8; m++) begin
      mode = m[2:0];
      cpu_wr(2'd2, 8'hFF); clr_flags();
      wr16(16'h00FF);
      run(1);
      rd16(v); chk("R3 count by mode", v, m[1] ? 16'h0100 : 16'h0000);
      cpu_rd(2'd3, d);
      chk("R3 ovf by mode", d[0], !m[1]);
      chk("R3 cmp by mode", d[1], m == 1);
    end

    // R5: 16-bit wrap
    mode = 3'b010; clr_flags();
    wr16(16'hFFFE); run(3);
    rd16(v); chk("R5 wrap count", v, 16'h0001);
    cpu_rd(2'd3, d); chk("R5 wrap overflow", d[0], 1);
    mode = 3'b110; clr_flags();
    wr16(16'h12F0); run(32);
    rd16(v); chk("R5 byte carry", v, 16'h1310);
    cpu_rd(2'd3, d); chk("R5 no overflow on byte carry", d[0], 0);

    // R9: temporary byte
    mode = 3'b010;
    wr16(16'h12FF);
    cpu_rd(2'd0, d); chk("R9 low read", d, 8'hFF);
    run(2);
    cpu_rd(2'd1, d); chk("R9 high from latched read", d, 8'h12);
    rd16(v); chk("R9 fresh read", v, 16'h1301);
    cpu_wr(2'd1, 8'hA5);
    rd16(v); chk("R9 high write alone leaves count", v, 16'h1301);
    wr16(16'hBEEF); rd16(v); chk("R9 paired write", v, 16'hBEEF);

    // R10: mode change
    wr16(16'h1234);
    mode = 3'b000; @(negedge clk);
    rd16(v); chk("R10 to 8-bit keeps low, clears high", v, 16'h0034);
    mode = 3'b010; @(negedge clk);
    rd16(v); chk("R10 back to 16-bit", v, 16'h0034);

    // R6: clear on compare
    mode = 3'b001;
    foreach (ocrs[i]) begin
      cpu_wr(2'd2, ocrs[i][7:0]); cpu_wr(2'd0, 8'h00); clr_flags();
      run(ocrs[i]);
      cpu_rd(2'd0, d); chk("R6 reaches compare", d, ocrs[i]);
      cpu_rd(2'd3, d); chk("R6 no flag before clear", d[1], 0);
      run(1);
      cpu_rd(2'd0, d); chk("R6 cleared", d, 0);
      cpu_rd(2'd3, d); chk("R6 cmp flag", d[1], 1);
      chk("R6 ovf only when compare=FF", d[0], ocrs[i] == 255);
    end

    // R7: missed match
    cpu_wr(2'd2, 8'd50); cpu_wr(2'd0, 8'd100); clr_flags();
    run(156);
    cpu_rd(2'd0, d); chk("R7 wrapped past FF", d, 0);
    cpu_rd(2'd3, d); chk("R7 ovf set, no cmp", d, 8'h01);
    run(51);
    cpu_rd(2'd0, d); chk("R7 match after wrap", d, 0);
    cpu_rd(2'd3, d); chk("R7 cmp after wrap", d[1], 1);

    // R2: write vs compare clear
    cpu_wr(2'd2, 8'd5); cpu_wr(2'd0, 8'd5); clr_flags();
    clk_sel = 1; addr = 0; wdata = 8'h20; wr = 1;
    @(negedge clk); wr = 0; clk_sel = 0;
    cpu_rd(2'd0, d); chk("R2 write beats clear", d, 8'h20);
    cpu_rd(2'd3, d); chk("R2 no cmp flag", d, 0);
    // R2: write vs wrap
    mode = 3'b000; cpu_wr(2'd0, 8'hFF);
    clk_sel = 1; addr = 0; wdata = 8'h10; wr = 1;
    @(negedge clk); wr = 0; clk_sel = 0;
    cpu_rd(2'd0, d); chk("R2 write beats increment", d, 8'h10);
    cpu_rd(2'd3, d); chk("R2 no ovf flag", d, 0);

    // R8: set wins over clear, clear rules
    cpu_wr(2'd0, 8'hFF);
    clk_sel = 1; addr = 3; wdata = 8'h01; wr = 1;
    @(negedge clk); wr = 0; clk_sel = 0;
    cpu_rd(2'd3, d); chk("R8 set wins over clear", d[0], 1);
    cpu_wr(2'd3, 8'h00);
    cpu_rd(2'd3, d); chk("R8 write 0 keeps", d[0], 1);
    cpu_wr(2'd3, 8'h01);
    cpu_rd(2'd3, d); chk("R8 write 1 clears", d[0], 0);
    cpu_wr(2'd0, 8'hFF); run(1);
    ovf_ack = 1; @(negedge clk); ovf_ack = 0;
    cpu_rd(2'd3, d); chk("R8 ack clears ovf", d[0], 0);
    mode = 3'b001; cpu_wr(2'd2, 8'd2); cpu_wr(2'd0, 8'd2); run(1);
    cpu_rd(2'd3, d); chk("R8 cmp set", d[1], 1);
    cmp_ack = 1; @(negedge clk); cmp_ack = 0;
    cpu_rd(2'd3, d); chk("R8 ack clears cmp", d[1], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule